// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Link Master

This block moves one byte across a three-wire serial link to a clock chip each time it is asked. The link has a serial clock line that rests high, a data line that both sides can drive, and a chip-enable line. This block does not drive chip-enable: the sequencer above it raises and lowers that line around a series of byte transfers and uses this block for each byte.

Each request selects one of two transfer kinds. A write shifts out a command or data byte with the most significant bit first. The block turns its data driver on only for the length of that byte. A read leaves the data driver off and collects eight bits, also most significant bit first. It returns only the low four of those bits; the upper bits of the result are zero. Each clock phase lasts a parameter number of system clock cycles. The default is 88 cycles, which at 125 MHz gives 704 ns per phase. The sequencer may request a transfer only while `ready_o` is high. A one-cycle `done_o` marks the end of each transfer.

Top module: `tw_link_master`

## Requirements
- R1: While reset is asserted and whenever the block is idle, the serial clock is high, the data output enable is low and `ready_o` is high.
- R2: A write sends exactly eight bits, most significant bit first. The bit seen on the data line at each falling edge of the serial clock is the next bit of the requested byte.
- R3: Every low phase of the serial clock, and every high phase between two bits, lasts exactly HALF_CYC system clock cycles.
- R4: In the first cycle after a write is accepted, the data line already carries bit 7 while the output enable is still low. The enable rises in the next cycle and is high at each of the eight falling edges.
- R5: During a write, the data line changes only while the serial clock is high and stays stable through every low phase.
- R6: In the cycle that `done_o` is high, the output enable is already low and the serial clock is back high.
- R7: During a read, the output enable is never asserted. Each bit is taken from `sdi_i` in the last high cycle before the falling edge for that bit.
- R8: A read returns a value on `rd_data_o` whose bits 7..4 are zero and whose bits 3..0 are the last four bits received, in arrival order with the last bit in bit 0.
- R9: `done_o` is a single-cycle pulse. Counting the clock edge that accepts `start_i` as edge 0, it first appears after edge 16*HALF_CYC+1 for a write and after edge 16*HALF_CYC for a read. The read result is valid in that same cycle.
- R10: The block ignores a `start_i` pulse that arrives while `ready_o` is low. The transfer in progress, its byte and its timing are unchanged, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, taken only when ready_o is high |
| rd_i | input | 1 | Transfer kind at request: 1 read, 0 write |
| wr_byte_i | input | BITS (8) | Byte to send on a write |
| ready_o | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | BITS (8) | Read result, low nibble only, valid with done_o |
| sclk_o | output | 1 | Serial clock, rests high |
| sdo_o | output | 1 | Value driven onto the data line |
| sdo_oe_o | output | 1 | Data line output enable |
| sdi_i | input | 1 | Data line as received |

## Verification
Each result has a fixed cycle. The write setup state is visible one cycle after the accepting edge and the output enable rises one cycle after that. Every serial clock phase lasts HALF_CYC cycles. `done_o` appears after edge 16*HALF_CYC+1 for a write and after edge 16*HALF_CYC for a read. The bench drives inputs and samples outputs on falling system clock edges. It counts edges from the accepting edge and compares that count with the formula. A slave model changes the received bit on each rising edge of the serial clock and records what it sees at each falling edge. It also measures the length of every phase, so bit order, phase length and data stability are checked in the cycle where they occur.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HIGH,
      ST_LOW,
      ST_FIN
   } tw_state_e;
endpackage

// File: rtl/tw_half_timer.sv
// Counts the cycles of one serial clock phase; expire_o marks its last cycle.
module tw_half_timer #(
   parameter int HALF_CYC = 88
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("tw_half_timer: HALF_CYC must be at least 1");
      end

      if (HALF_CYC == 1) begin : g_single
         assign expire_o = run_i;
      end else begin : g_count
         logic [CW-1:0] cnt;
         logic          at_end;

         assign at_end   = (cnt == CW'(HALF_CYC - 1));
         assign expire_o = run_i && at_end;

         always_ff @(posedge clk) begin
            if (rst || !run_i) cnt <= '0;
            else if (at_end)   cnt <= '0;
            else               cnt <= cnt + 1'b1;
         end

         // R3: a running phase advances by exactly one cycle per clock
         p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
            (run_i && !expire_o) |=> (!run_i || cnt == $past(cnt) + 1'b1));
      end
   endgenerate
endmodule

// File: rtl/tw_shifter.sv
// Shared shift register: serialises a write byte or assembles a read byte.
module tw_shifter #(
   parameter int BITS = 8,
   parameter int KEEP = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_i,
   input  logic [BITS-1:0] din_i,
   input  logic            shift_i,
   input  logic            sin_i,
   output logic            msb_o,
   output logic [BITS-1:0] kept_o
);
   logic [BITS-1:0] sh;

   generate
      if (BITS < 2) begin : g_bad_bits
         $error("tw_shifter: BITS must be at least 2");
      end
      if (KEEP < 1) begin : g_bad_keep
         $error("tw_shifter: KEEP must be at least 1");
      end

      if (KEEP >= BITS) begin : g_keep_all
         assign kept_o = sh;
      end else begin : g_keep_low
         assign kept_o = {{(BITS-KEEP){1'b0}}, sh[KEEP-1:0]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          sh <= '0;
      else if (load_i)  sh <= din_i;
      else if (shift_i) sh <= {sh[BITS-2:0], sin_i};
   end

   assign msb_o = sh[BITS-1];

   // R2: a load without a shift puts the requested byte's top bit on the line
   p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
      load_i |=> (msb_o == $past(din_i[BITS-1])));
endmodule

// File: rtl/tw_link_master.sv
module tw_link_master #(
   parameter int BITS      = 8,
   parameter int HALF_CYC  = 88,
   parameter int KEEP_BITS = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start_i,
   input  logic            rd_i,
   input  logic [BITS-1:0] wr_byte_i,
   output logic            ready_o,
   output logic            done_o,
   output logic [BITS-1:0] rd_data_o,
   output logic            sclk_o,
   output logic            sdo_o,
   output logic            sdo_oe_o,
   input  logic            sdi_i
);
   import tw_pkg::*;

   localparam int IW = (BITS > 1) ? $clog2(BITS) : 1;

   generate
      if (KEEP_BITS > BITS) begin : g_bad_keep
         $error("tw_link_master: KEEP_BITS must not exceed BITS");
      end
   endgenerate

   tw_state_e       state;
   logic            rd_q;
   logic [IW-1:0]   bidx;
   logic            tick;
   logic            last_bit;
   logic            take;
   logic            sh_load;
   logic            sh_shift;
   logic [BITS-1:0] kept;
   logic [BITS-1:0] load_val;

   assign take     = (state == ST_IDLE) && start_i;
   assign last_bit = (bidx == IW'(BITS - 1));
   assign sh_load  = take;
   assign load_val = rd_i ? '0 : wr_byte_i;
   assign sh_shift = tick && ((rd_q && state == ST_HIGH) ||
                              (!rd_q && state == ST_LOW && !last_bit));

   tw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .run_i    ((state == ST_HIGH) || (state == ST_LOW)),
      .expire_o (tick)
   );

   tw_shifter #(.BITS(BITS), .KEEP(KEEP_BITS)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .load_i  (sh_load),
      .din_i   (load_val),
      .shift_i (sh_shift),
      .sin_i   (sdi_i),
      .msb_o   (sdo_o),
      .kept_o  (kept)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         rd_q      <= 1'b0;
         bidx      <= '0;
         sdo_oe_o  <= 1'b0;
         rd_data_o <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  rd_q  <= rd_i;
                  bidx  <= '0;
                  state <= rd_i ? ST_HIGH : ST_SETUP;
               end
            end
            ST_SETUP: begin
               sdo_oe_o <= 1'b1;
               state    <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) state <= ST_LOW;
            end
            ST_LOW: begin
               if (tick) begin
                  if (last_bit) begin
                     sdo_oe_o <= 1'b0;
                     if (rd_q) rd_data_o <= kept;
                     state <= ST_FIN;
                  end else begin
                     bidx  <= bidx + 1'b1;
                     state <= ST_HIGH;
                  end
               end
            end
            ST_FIN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ready_o = (state == ST_IDLE);
   assign done_o  = (state == ST_FIN);
   assign sclk_o  = (state != ST_LOW);

   // R1: idle leaves the clock high and the data driver off
   p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
      ready_o |-> (sclk_o && !sdo_oe_o));
   // R4: on a write the driver is on at every falling edge
   p_oe_at_fall_r4: assert property (@(posedge clk) disable iff (rst)
      ($fell(sclk_o) && !rd_q) |-> sdo_oe_o);
   // R5: driven data does not move during a low phase
   p_sdo_stable_r5: assert property (@(posedge clk) disable iff (rst)
      (sdo_oe_o && !sclk_o && !$past(sclk_o)) |-> $stable(sdo_o));
   // R6: completion shows the line released and the clock high
   p_release_r6: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!sdo_oe_o && sclk_o));
   // R7: a read never drives the data line
   p_no_drive_read_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_q && !ready_o) |-> !sdo_oe_o);
   // R9: completion lasts one cycle and returns to idle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      done_o |=> (!done_o && ready_o));
   // R10: the transfer kind cannot change while busy
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
      (!ready_o && !done_o) |=> $stable(rd_q));
endmodule

// File: tb/sim_tw_link_master.sv
`timescale 1ns/1ps
module sim_tw_link_master;
   localparam int BITS = 8;
   localparam int H    = 88;

   logic            clk = 1'b0;
   logic            rst;
   logic            start_i;
   logic            rd_i;
   logic [BITS-1:0] wr_byte_i;
   logic            ready_o, done_o, sclk_o, sdo_o, sdo_oe_o;
   logic [BITS-1:0] rd_data_o;
   logic            sdi_i;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   tw_link_master #(.BITS(BITS), .HALF_CYC(H), .KEEP_BITS(4)) u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i),
      .wr_byte_i(wr_byte_i), .ready_o(ready_o), .done_o(done_o),
      .rd_data_o(rd_data_o), .sclk_o(sclk_o), .sdo_o(sdo_o),
      .sdo_oe_o(sdo_oe_o), .sdi_i(sdi_i)
   );

   // slave model and line monitor
   logic       mon_clr = 1'b0;
   logic       tb_read = 1'b0;
   logic [7:0] slave_byte = 8'h00;
   int         slave_idx;
   logic       prev_sclk;
   logic       last_sdo;
   logic [7:0] fall_bits;
   int         falls, rises, run_len, bad_len, oe_bad, low_change, oe_in_read;

   assign sdi_i = (slave_idx < 8) ? slave_byte[7 - slave_idx] : 1'b0;

   always @(negedge clk) begin
      if (mon_clr) begin
         slave_idx <= 0; prev_sclk <= 1'b1; last_sdo <= sdo_o; fall_bits <= '0;
         falls <= 0; rises <= 0; run_len <= 1; bad_len <= 0; oe_bad <= 0;
         low_change <= 0; oe_in_read <= 0;
      end else begin
         if (prev_sclk && !sclk_o) begin
            fall_bits <= {fall_bits[6:0], sdo_o};
            falls     <= falls + 1;
            if (!sdo_oe_o && !tb_read) oe_bad <= oe_bad + 1;
            if (rises > 0 && run_len != H) bad_len <= bad_len + 1;
            run_len <= 1;
         end else if (!prev_sclk && sclk_o) begin
            rises     <= rises + 1;
            slave_idx <= slave_idx + 1;
            if (run_len != H) bad_len <= bad_len + 1;
            run_len <= 1;
         end else begin
            run_len <= run_len + 1;
         end
         if (!prev_sclk && !sclk_o && sdo_o != last_sdo && !tb_read)
            low_change <= low_change + 1;
         if (tb_read && sdo_oe_o) oe_in_read <= oe_in_read + 1;
         prev_sclk <= sclk_o;
         last_sdo  <= sdo_o;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_monitor();
      @(negedge clk); mon_clr = 1'b1;
      @(negedge clk);
      @(posedge clk); #1 mon_clr = 1'b0;
   endtask

   // counts edges after the accepting edge until done; returns count
   task automatic wait_done(input int limit, input bit poke, output int n);
      n = 0;
      while (!done_o && n < limit) begin
         @(negedge clk);
         n++;
         if (poke && n == 3*H) begin start_i = 1'b1; rd_i = 1'b1; wr_byte_i = 8'hFF; end
         else if (poke && n == 3*H + 1) begin start_i = 1'b0; rd_i = 1'b0; end
      end
   endtask

   task automatic do_write(input logic [7:0] b, input bit poke);
      int n;
      clear_monitor();
      tb_read = 1'b0;
      @(negedge clk); start_i = 1'b1; rd_i = 1'b0; wr_byte_i = b;
      @(negedge clk); start_i = 1'b0; wr_byte_i = 8'h00;
      chk(sdo_o == b[7] && !sdo_oe_o && !ready_o, "R4 setup", {sdo_o, sdo_oe_o}, {b[7], 1'b0});
      @(negedge clk);
      chk(sdo_oe_o && sclk_o, "R4 enable", sdo_oe_o, 1);
      n = 1;
      begin
         int m;
         wait_done(20*H, poke, m);
         n += m;
      end
      chk(n == 16*H + 1, poke ? "R10 timing" : "R9 write done", n, 16*H + 1);
      chk(!sdo_oe_o && sclk_o, "R6 release", {sdo_oe_o, sclk_o}, 2'b01);
      chk(fall_bits == b && falls == 8, poke ? "R10 byte" : "R2 bits", fall_bits, b);
      chk(bad_len == 0, "R3 phase length", bad_len, 0);
      chk(oe_bad == 0, "R4 enable at falls", oe_bad, 0);
      chk(low_change == 0, "R5 stable low", low_change, 0);
      @(negedge clk);
      chk(!done_o && ready_o, "R9 single pulse", done_o, 0);
      if (poke) begin
         repeat (3*H) @(negedge clk);
         chk(ready_o && sclk_o && falls == 8, "R10 no second transfer", falls, 8);
      end
   endtask

   task automatic do_read(input logic [7:0] s);
      int n;
      slave_byte = s;
      tb_read = 1'b1;
      clear_monitor();
      @(negedge clk); start_i = 1'b1; rd_i = 1'b1;
      @(negedge clk); start_i = 1'b0; rd_i = 1'b0;
      wait_done(20*H, 1'b0, n);
      chk(n == 16*H, "R9 read done", n, 16*H);
      chk(rd_data_o == {4'h0, s[3:0]}, "R8 read nibble", rd_data_o, {4'h0, s[3:0]});
      chk(oe_in_read == 0, "R7 no drive", oe_in_read, 0);
      chk(bad_len == 0 && falls == 8, "R3 read phases", bad_len, 0);
      @(negedge clk);
      chk(!done_o && ready_o, "R9 read single pulse", done_o, 0);
      tb_read = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; start_i = 1'b0; rd_i = 1'b0; wr_byte_i = '0;
      repeat (3) @(negedge clk);
      chk(sclk_o && !sdo_oe_o && ready_o && !done_o, "R1 reset", {sclk_o, sdo_oe_o, ready_o, done_o}, 4'b1010);
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      chk(sclk_o && !sdo_oe_o && ready_o, "R1 idle", {sclk_o, sdo_oe_o, ready_o}, 3'b101);
      do_write(8'hE5, 1'b0);
      do_write(8'h5A, 1'b0);
      do_write(8'h81, 1'b0);
      do_read(8'hA5);
      do_read(8'h3C);
      do_read(8'hFF);
      do_write(8'h00, 1'b0);
      do_write(8'hC3, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule